// File: doc/BRIEF.md
# Infrared Narrow-Pulse Receive Detector

This block sits between a raw infrared photodiode input and a UART receive deserializer. The infrared link marks each zero bit with a short pulse and leaves one bits as no pulse at all. The block turns that pulse stream back into an ordinary NRZ line that idles high. The raw input first passes through a synchroniser. An optional inversion is then applied, so that either pulse polarity can be used. The first edge of each pulse starts a small counter on the system clock. When the counter runs out, the block tests the input again. If the pulse has gone, the event is dropped as a glitch and a one-cycle reject strobe is raised. If the pulse is still there, it counts as a received zero.

A qualified pulse drives the NRZ output low for exactly one bit time. That bit time is counted in ticks of an externally supplied 16x oversampling strobe. The bit-time counter is reloaded on every qualified pulse, so the sampling window is realigned on each start bit. A single-cycle sample strobe marks the middle of the window, so the deserializer can sample the bit at its centre.

Top module: `irda_pulse_rx`

## Requirements
- R1: While reset is asserted and right after it, `nrz_out` is 1 and `glitch_rej` and `bit_sample` are 0.
- R2: With `pol_low`=0 a pulse is `ir_in`=1. With `pol_low`=1 a pulse is `ir_in`=0. An input held continuously at its idle level never lowers `nrz_out` and never raises `glitch_rej`.
- R3: A pulse whose active level lasts 16 system clock cycles or fewer gives exactly one `glitch_rej` strobe and leaves `nrz_out` high.
- R4: A pulse whose active level lasts 17 cycles or more lowers `nrz_out` once and gives no `glitch_rej` strobe.
- R5: A new pulse edge that arrives while the qualification counter is running does not restart it. The verdict is taken 16 cycles after the first edge.
- R6: After a qualified pulse, `nrz_out` stays low for exactly 16 ticks of `tick16`, counting the tick on which it returns high, and then goes back to 1.
- R7: Each low window gives exactly one `bit_sample` strobe. The strobe follows the 8th `tick16` of that window.
- R8: A pulse that qualifies while `nrz_out` is already low reloads the window. The line stays low without a break until 16 ticks after the new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the glitch counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw infrared pulse input, asynchronous |
| pol_low | input | 1 | 0: pulses are high; 1: pulses are low |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| nrz_out | output | 1 | Recovered NRZ line, idles high |
| glitch_rej | output | 1 | One-cycle strobe per rejected glitch |
| bit_sample | output | 1 | One-cycle strobe at the centre of each low bit window |

## Verification
The bench tests the filter at its exact threshold. It uses pulses of 16 and 17 cycles in both polarities. A counter off by one would reject or accept the wrong width at that threshold. It also sends a short pulse, a short gap and then a 14-cycle pulse. A design that restarts the counter on the second edge would reject this train instead of accepting it. The bench counts the ticks in each low window and notes where the sample strobe lands. A window that is too long or too short, or a sample strobe placed off centre, shows up as a wrong count. A second pulse sent during a low window checks that the window is reloaded. A design that does not reload would show two falling edges on the line.

// File: rtl/irda_rx_pkg.sv
package irda_rx_pkg;
    typedef enum logic [1:0] {
        VERD_NONE   = 2'd0,
        VERD_GLITCH = 2'd1,
        VERD_PULSE  = 2'd2
    } verdict_e;
endpackage

// File: rtl/irda_sync.sv
module irda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/irda_glitch_qual.sv
module irda_glitch_qual
    import irda_rx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     act,
    output verdict_e verdict,
    output logic     rej_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             rej;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = act;
        st_d.rej  = 1'b0;
        verdict   = VERD_NONE;
        if (st_q.run) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
                if (act) begin
                    verdict = VERD_PULSE;
                end else begin
                    verdict  = VERD_GLITCH;
                    st_d.rej = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (act && !st_q.prev) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rej_o = st_q.rej;

    AST_REJ_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rej |-> $past(st_q.run)); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run)) |-> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R5
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (st_q.cnt == '0)); // R5
endmodule

// File: rtl/irda_bit_window.sv
module irda_bit_window
    import irda_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  verdict_e verdict,
    output logic     nrz_o,
    output logic     samp_o
);
    localparam int TW = (OVS > 2) ? $clog2(OVS) : 1;
    localparam logic [TW-1:0] LAST = TW'(OVS - 1);
    localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);

    typedef struct packed {
        logic          low;
        logic [TW-1:0] cnt;
        logic          samp;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        w_d.samp = 1'b0;
        if (verdict == VERD_PULSE) begin
            w_d.low = 1'b1;
            w_d.cnt = '0;
        end else if (w_q.low && tick) begin
            if (w_q.cnt == MID) w_d.samp = 1'b1;
            if (w_q.cnt == LAST) begin
                w_d.low = 1'b0;
                w_d.cnt = '0;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign nrz_o  = ~w_q.low;
    assign samp_o = w_q.samp;

    AST_SAMPLE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.samp |-> w_q.low); // R7
    AST_LOW_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_q.low) |-> $past(verdict == VERD_PULSE)); // R4
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(w_q.low) |-> $past(tick)); // R6
endmodule

// File: rtl/irda_pulse_rx.sv
module irda_pulse_rx
    import irda_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_W    = 4,
    parameter int OVS         = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_in,
    input  logic pol_low,
    input  logic tick16,
    output logic nrz_out,
    output logic glitch_rej,
    output logic bit_sample
);
    logic     sync_s;
    logic     act_s;
    verdict_e verd_s;

    irda_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ir_in),
        .dout (sync_s)
    );

    assign act_s = sync_s ^ pol_low;

    irda_glitch_qual #(.CNT_W(GLITCH_W)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act_s),
        .verdict(verd_s),
        .rej_o  (glitch_rej)
    );

    irda_bit_window #(.OVS(OVS)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .verdict(verd_s),
        .nrz_o  (nrz_out),
        .samp_o (bit_sample)
    );

    AST_REJ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_rej |=> !glitch_rej); // R3
endmodule

// File: tb/sim_irda_pulse_rx.sv
`timescale 1ns/1ps
module sim_irda_pulse_rx;
    logic clk = 0, rst_n = 0, ir_in = 0, pol_low = 0, tick16 = 0;
    logic nrz_out, glitch_rej, bit_sample;
    int checks = 0, failures = 0;
    int cyc = 0, falls = 0, rejs = 0, samples = 0, low_ticks = 0;
    int run_ticks = 0, samp_at = -1, div = 0;
    logic prev_nrz = 1;

    irda_pulse_rx u0 (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .pol_low(pol_low),
        .tick16(tick16), .nrz_out(nrz_out), .glitch_rej(glitch_rej), .bit_sample(bit_sample));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        #2;
        div    = (div + 1) % 4;
        tick16 = (div == 0);
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (prev_nrz && !nrz_out) begin falls++; run_ticks = 0; end
        if (bit_sample) begin samples++; samp_at = run_ticks; end
        if (!nrz_out && tick16) begin low_ticks++; run_ticks++; end
        if (glitch_rej) rejs++;
        prev_nrz = nrz_out;
        if (cyc == 150000) begin
            failures++; checks++;
            $display("FAIL watchdog: act=%0d exp<%0d", cyc, 150000);
            summary();
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input bit a);
        @(negedge clk);
        ir_in = pol_low ^ a;
    endtask

    task automatic pulse(input int w);
        drive(1'b1);
        idle(w - 1);
        drive(1'b0);
    endtask

    localparam int NV = 9;
    localparam int VP [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
    localparam int VW [NV] = '{1, 8, 16, 17, 40, 3, 16, 17, 25};
    localparam int VA [NV] = '{0, 0, 0, 1, 1, 0, 0, 1, 1};

    int f0, r0, s0, t0;

    task automatic snap();
        f0 = falls; r0 = rejs; s0 = samples; t0 = low_ticks; samp_at = -1;
    endtask

    initial begin
        idle(3);
        // R1: reset values while reset is held
        chk(nrz_out == 1 && glitch_rej == 0 && bit_sample == 0, "R1 in reset",
            {nrz_out, glitch_rej, bit_sample}, 3'b100);
        @(negedge clk); rst_n = 1;
        idle(2);
        chk(nrz_out == 1 && glitch_rej == 0 && bit_sample == 0, "R1 after reset",
            {nrz_out, glitch_rej, bit_sample}, 3'b100);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pol_low = VP[i][0];
            ir_in   = VP[i][0];
            idle(40);
            snap();
            pulse(VW[i]);
            idle(150);
            // R3 / R4 with R2 polarity
            chk((rejs - r0) == 1 - VA[i], $sformatf("R3/R2 rejects pol=%0d w=%0d", VP[i], VW[i]),
                rejs - r0, 1 - VA[i]);
            chk((falls - f0) == VA[i], $sformatf("R4/R2 falls pol=%0d w=%0d", VP[i], VW[i]),
                falls - f0, VA[i]);
            if (VA[i] == 1) begin
                chk((low_ticks - t0) == 16, $sformatf("R6 low ticks w=%0d", VW[i]), low_ticks - t0, 16);
                chk((samples - s0) == 1, "R7 sample count", samples - s0, 1);
                chk(samp_at == 8, "R7 sample position", samp_at, 8);
                chk(nrz_out == 1, "R6 back high", nrz_out, 1);
            end
        end

        // R2: idle level held long, polarity low
        @(negedge clk); pol_low = 1; ir_in = 1;
        idle(40); snap(); idle(300);
        chk(falls == f0 && rejs == r0, "R2 idle high pol=1", (falls - f0) + (rejs - r0), 0);

        // R2: idle level held long, polarity high
        @(negedge clk); pol_low = 0; ir_in = 0;
        idle(40); snap(); idle(300);
        chk(falls == f0 && rejs == r0, "R2 idle low pol=0", (falls - f0) + (rejs - r0), 0);

        // R5: edge during counting must not restart it
        snap();
        pulse(2); idle(1); pulse(14);
        idle(150);
        chk((falls - f0) == 1, "R5 accepted without restart", falls - f0, 1);
        chk((rejs - r0) == 0, "R5 no reject", rejs - r0, 0);

        // R8: second qualified pulse during low window reloads it
        snap();
        pulse(20); idle(29); pulse(20);
        idle(200);
        chk((falls - f0) == 1, "R8 single fall", falls - f0, 1);
        chk((low_ticks - t0) >= 27 && (low_ticks - t0) <= 30, "R8 extended window",
            low_ticks - t0, 28);
        chk((samples - s0) == 2, "R8 two samples", samples - s0, 2);
        chk(nrz_out == 1, "R8 back high", nrz_out, 1);

        summary();
    end
endmodule